// File: doc/BRIEF.md
# Bus-idle automatic power-down controller

This block sits between an 8-bit microcontroller bus and the memories and programmable-logic arrays behind it. It watches the address strobe. When no rising strobe edge has arrived for a programmed number of timer ticks, the block enters power-down. While it is powered down, it freezes the multiplexed address/data lines that it passes downstream and forces every memory select inactive. Bus noise and traffic from other devices therefore cannot disturb the memories. The first strobe edge seen while powered down brings the block back to the active state.

A small set of mode registers is written by the MCU at run time:

- **Mode register:** holds a turbo-disable bit.
- **Idle register:** holds the idle limit. A limit of zero turns automatic power-down off.
- **Mask register:** holds one blocking bit per logic-array input. A blocked input is frozen at its last sampled value, so the downstream logic stops seeing transitions.

A separate active-low chip select deselects the memories without gating any signal.

Top module: `apd_ctrl`

## Requirements
- R1: After reset, `pdn_o` is 0 and `turbo_en_o` is 1. The idle limit is 0 and no input is blocked, so `ad_o` equals `ad_i`, `pld_in_o` equals `pld_in_i`, and `mem_sel_o` equals `mem_sel_i` while `csn_i` is 0.
- R2: With a non-zero idle limit L (register address 1, bits [TMR_W-1:0]), take the clock edge that first samples `ale_i` high after it was low. If no further rising edge occurs, `pdn_o` goes to 1 exactly L*TICK_DIV clock cycles after that edge.
- R3: A rising strobe edge while active restarts the idle count from zero. `pdn_o` stays 0 until L*TICK_DIV cycles after the newest edge.
- R4: While the idle limit is 0, `pdn_o` never rises, however long the strobe stays idle.
- R5: While `pdn_o` is 1, `ad_o` holds the value `ad_i` had at the clock edge that set `pdn_o`. Any toggling of `ad_i` is ignored.
- R6: While `pdn_o` is 1, every bit of `mem_sel_o` is 0.
- R7: The first rising strobe edge seen while powered down clears `pdn_o` on that same clock edge. After it, `ad_o` and `mem_sel_o` follow their inputs again. The idle count restarts, so `pdn_o` returns L*TICK_DIV cycles later.
- R8: Each set bit i of the mask register (address 2) holds `pld_in_o[i]` at the value `pld_in_i[i]` had at the write edge. Clear bits pass through unchanged. Clearing a bit restores pass-through. Power-down does not block `pld_in_o`.
- R9: Writing 1 to bit 0 of the mode register (address 0) drives `turbo_en_o` to 0 from the next cycle. Writing 0 to that bit drives it back to 1.
- R10: `csn_i` = 1 forces `mem_sel_o` to 0. It leaves `ad_o` and `pld_in_o` passing their inputs, and it does not change `pdn_o`.
- R11: A write to register address 3 has no effect on `turbo_en_o`, the blocking of `pld_in_o`, or the idle limit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address strobe from the MCU, active high |
| ad_i | input | AD_W | Multiplexed address/data from the MCU bus |
| pld_in_i | input | BLK_W | Logic-array inputs before blocking |
| mem_sel_i | input | NUM_MEM | Decoded memory selects before gating |
| csn_i | input | 1 | Chip select, active low |
| reg_we_i | input | 1 | Mode register write strobe |
| reg_addr_i | input | 2 | Mode register address |
| reg_wdata_i | input | REG_W | Mode register write data |
| ad_o | output | AD_W | Address/data to memories and logic arrays |
| pld_in_o | output | BLK_W | Logic-array inputs after blocking |
| mem_sel_o | output | NUM_MEM | Memory selects after gating |
| turbo_en_o | output | 1 | Turbo mode enable |
| pdn_o | output | 1 | Power-down state |

## Verification
The bench builds the block with TICK_DIV = 2 and otherwise default widths: 8 address/data bits, 8 blockable inputs and 3 memory selects. With that divider, an idle limit of 3 expires in 6 cycles. The bench can therefore count the exact entry cycle, restart the count partway through, and observe wake and re-entry within a few dozen cycles. The 8-bit mask covers mixed blocked and passing bits in one pattern, and the short window leaves room to show that a zero limit never powers down.

// File: rtl/apd_pkg.sv
package apd_pkg;
  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_IDLE  = 2'd1,
    REG_MASK  = 2'd2,
    REG_SPARE = 2'd3
  } apd_reg_e;

  localparam int unsigned TURBO_OFF_BIT = 0;
endpackage

// File: rtl/apd_regs.sv
module apd_regs
  import apd_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned TMR_W = 4,
  parameter int unsigned BLK_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             turbo_off_o,
  output logic [TMR_W-1:0] idle_lim_o,
  output logic [BLK_W-1:0] mask_o
);
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      turbo_off_o <= 1'b0;
      idle_lim_o  <= '0;
      mask_o      <= '0;
    end else if (we_i) begin
      unique case (apd_reg_e'(addr_i))
        REG_MODE:  turbo_off_o <= wdata_i[TURBO_OFF_BIT];
        REG_IDLE:  idle_lim_o  <= wdata_i[TMR_W-1:0];
        REG_MASK:  mask_o      <= wdata_i[BLK_W-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/apd_idle.sv
module apd_idle #(
  parameter int unsigned TMR_W    = 4,
  parameter int unsigned TICK_DIV = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic [TMR_W-1:0] idle_lim_i,
  output logic             pdn_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic             ale_q;
  logic             strobe_edge;
  logic [PRE_W-1:0] pre_q;
  logic             tick;
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W:0]   cnt_inc;

  assign strobe_edge = ale_i & ~ale_q;
  assign tick        = (pre_q == PRE_MAX);
  assign cnt_inc     = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ale_q <= 1'b0;
    else         ale_q <= ale_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pre_q <= '0;
    else if (strobe_edge || tick) pre_q <= '0;
    else                          pre_q <= pre_q + 1'b1;
  end

  // strobe edge wins over expiry; wake and restart share the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pdn_o <= 1'b0;
    end else if (strobe_edge) begin
      cnt_q <= '0;
      pdn_o <= 1'b0;
    end else if (!pdn_o && (idle_lim_i != '0) && tick) begin
      if (cnt_inc >= {1'b0, idle_lim_i}) pdn_o <= 1'b1;
      else                               cnt_q <= cnt_inc[TMR_W-1:0];
    end
  end
endmodule

// File: rtl/apd_hold_gate.sv
module apd_hold_gate #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  input  logic [W-1:0] block_i,
  output logic [W-1:0] out_o
);
  logic [W-1:0] hold_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          hold_q[g] <= 1'b0;
      else if (!block_i[g]) hold_q[g] <= in_i[g];
    end
    assign out_o[g] = block_i[g] ? hold_q[g] : in_i[g];
  end
endmodule

// File: rtl/apd_ctrl.sv
module apd_ctrl #(
  parameter int unsigned AD_W     = 8,
  parameter int unsigned BLK_W    = 8,
  parameter int unsigned NUM_MEM  = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned TMR_W    = 4,
  parameter int unsigned TICK_DIV = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ale_i,
  input  logic [AD_W-1:0]    ad_i,
  input  logic [BLK_W-1:0]   pld_in_i,
  input  logic [NUM_MEM-1:0] mem_sel_i,
  input  logic               csn_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [AD_W-1:0]    ad_o,
  output logic [BLK_W-1:0]   pld_in_o,
  output logic [NUM_MEM-1:0] mem_sel_o,
  output logic               turbo_en_o,
  output logic               pdn_o
);
  logic             turbo_off;
  logic [TMR_W-1:0] idle_lim;
  logic [BLK_W-1:0] mask;
  logic             pdn;

  apd_regs #(.REG_W(REG_W), .TMR_W(TMR_W), .BLK_W(BLK_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .turbo_off_o (turbo_off),
    .idle_lim_o  (idle_lim),
    .mask_o      (mask)
  );

  apd_idle #(.TMR_W(TMR_W), .TICK_DIV(TICK_DIV)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ale_i      (ale_i),
    .idle_lim_i (idle_lim),
    .pdn_o      (pdn)
  );

  apd_hold_gate #(.W(AD_W)) u_ad_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (ad_i),
    .block_i ({AD_W{pdn}}),
    .out_o   (ad_o)
  );

  apd_hold_gate #(.W(BLK_W)) u_pld_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .in_i    (pld_in_i),
    .block_i (mask),
    .out_o   (pld_in_o)
  );

  assign mem_sel_o  = mem_sel_i & {NUM_MEM{~pdn & ~csn_i}};
  assign turbo_en_o = ~turbo_off;
  assign pdn_o      = pdn;
endmodule

// File: rtl/apd_ctrl_chk.sv
module apd_ctrl_chk #(
  parameter int unsigned AD_W    = 8,
  parameter int unsigned NUM_MEM = 3,
  parameter int unsigned REG_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ale_i,
  input logic [AD_W-1:0]    ad_i,
  input logic               csn_i,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [REG_W-1:0]   reg_wdata_i,
  input logic [AD_W-1:0]    ad_o,
  input logic [NUM_MEM-1:0] mem_sel_o,
  input logic               turbo_en_o,
  input logic               pdn_o
);
  p_mem_off_pdn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_o |-> (mem_sel_o == '0));

  p_ad_frozen_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_o && $past(pdn_o)) |-> $stable(ad_o));

  p_ad_pass_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_o |-> (ad_o == ad_i));

  p_wake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pdn_o && ale_i && !$past(ale_i)) |=> !pdn_o);

  p_no_entry_on_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pdn_o && ale_i && !$past(ale_i)) |=> !pdn_o);

  p_csn_desel_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_i |-> (mem_sel_o == '0));

  p_turbo_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd0) |=> (turbo_en_o == !$past(reg_wdata_i[0])));

  p_spare_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd3) |=> $stable(turbo_en_o));
endmodule

bind apd_ctrl apd_ctrl_chk #(.AD_W(AD_W), .NUM_MEM(NUM_MEM), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ale_i       (ale_i),
  .ad_i        (ad_i),
  .csn_i       (csn_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .ad_o        (ad_o),
  .mem_sel_o   (mem_sel_o),
  .turbo_en_o  (turbo_en_o),
  .pdn_o       (pdn_o)
);

// File: tb/apd_ctrl_tb.sv
module apd_ctrl_tb;
  localparam int unsigned AD_W = 8, BLK_W = 8, NUM_MEM = 3, REG_W = 8, TMR_W = 4;
  localparam int unsigned DIV = 2;
  localparam int unsigned LIM = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               ale = 1'b0;
  logic [AD_W-1:0]    ad = '0;
  logic [BLK_W-1:0]   pld = '0;
  logic [NUM_MEM-1:0] msel = '0;
  logic               csn = 1'b0;
  logic               we = 1'b0;
  logic [1:0]         addr = '0;
  logic [REG_W-1:0]   wdata = '0;
  logic [AD_W-1:0]    ad_o;
  logic [BLK_W-1:0]   pld_o;
  logic [NUM_MEM-1:0] msel_o;
  logic               turbo_o;
  logic               pdn_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  apd_ctrl #(.AD_W(AD_W), .BLK_W(BLK_W), .NUM_MEM(NUM_MEM), .REG_W(REG_W),
             .TMR_W(TMR_W), .TICK_DIV(DIV)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ad_i(ad), .pld_in_i(pld),
    .mem_sel_i(msel), .csn_i(csn), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .ad_o(ad_o), .pld_in_o(pld_o), .mem_sel_o(msel_o),
    .turbo_en_o(turbo_o), .pdn_o(pdn_o)
  );

  // {csn, mem_sel_i, ad_i, expected mem_sel_o}
  localparam logic [14:0] VEC [8] = '{
    {1'b0, 3'b111, 8'h00, 3'b111},
    {1'b0, 3'b101, 8'hFF, 3'b101},
    {1'b1, 3'b111, 8'hA5, 3'b000},
    {1'b0, 3'b010, 8'h5A, 3'b010},
    {1'b1, 3'b001, 8'h3C, 3'b000},
    {1'b0, 3'b100, 8'hC3, 3'b100},
    {1'b1, 3'b000, 8'h81, 3'b000},
    {1'b0, 3'b011, 8'h7E, 3'b011}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  // ends at the negedge after the edge that samples the strobe rise
  task automatic strobe();
    @(negedge clk);
    ale = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ale = 1'b0;
  endtask

  task automatic timer_check(input string req);
    repeat (LIM*DIV - 1) @(posedge clk);
    @(negedge clk);
    check(req, pdn_o, 1'b0);
    @(posedge clk);
    @(negedge clk);
    check(req, pdn_o, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 pdn", pdn_o, 1'b0);
    check("R1 turbo", turbo_o, 1'b1);
    rst_n = 1'b1;
    msel = 3'b110; ad = 8'h96; pld = 8'h69;
    #2;
    check("R1 ad pass", ad_o, 8'h96);
    check("R1 pld pass", pld_o, 8'h69);
    check("R1 msel pass", msel_o, 3'b110);

    // R10 table walk: chip select gating, ad passes
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      {csn, msel, ad} = VEC[i][14:3];
      #2;
      check("R10 msel", msel_o, VEC[i][2:0]);
      check("R10 ad", ad_o, VEC[i][10:3]);
      check("R10 pdn", pdn_o, 1'b0);
    end
    csn = 1'b0;

    // R4 zero limit never powers down
    strobe();
    repeat (100) @(posedge clk);
    @(negedge clk);
    check("R4 no pdn", pdn_o, 1'b0);

    // R9 turbo bit
    wr(2'd0, 8'h01);
    check("R9 turbo off", turbo_o, 1'b0);
    wr(2'd0, 8'h00);
    check("R9 turbo on", turbo_o, 1'b1);

    // R11 spare address has no effect
    wr(2'd3, 8'hFF);
    pld = 8'h33;
    #2;
    check("R11 turbo", turbo_o, 1'b1);
    check("R11 pld pass", pld_o, 8'h33);

    // R8 per-bit blocking
    @(negedge clk);
    pld = 8'hA5;
    wr(2'd2, 8'h0F);
    pld = 8'h5A;
    #2;
    check("R8 mixed", pld_o, 8'h55);
    wr(2'd2, 8'h00);
    #2;
    check("R8 restore", pld_o, 8'h5A);

    // R11 idle limit untouched by spare write: still no pdn
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R11 lim", pdn_o, 1'b0);

    // R3 restart, then R2 exact entry
    wr(2'd1, 8'(LIM));
    ad = 8'h3C; msel = 3'b111;
    strobe();
    repeat (4) @(posedge clk);
    strobe();
    timer_check("R2 R3 entry");

    // R5 / R6 / R8 during pdn
    ad = 8'hC3;
    pld = 8'hF0;
    #2;
    check("R5 ad held", ad_o, 8'h3C);
    check("R6 msel off", msel_o, 3'b000);
    check("R8 pld unblocked in pdn", pld_o, 8'hF0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    ad = 8'h11;
    #2;
    check("R5 still held", ad_o, 8'h3C);

    // R7 wake and re-entry
    ad = 8'hC3;
    strobe();
    check("R7 wake", pdn_o, 1'b0);
    check("R7 ad pass", ad_o, 8'hC3);
    check("R7 msel pass", msel_o, 3'b111);
    timer_check("R7 re-entry");

    // R4 limit 0 after wake
    strobe();
    wr(2'd1, 8'h00);
    repeat (50) @(posedge clk);
    @(negedge clk);
    check("R4 disabled", pdn_o, 1'b0);

    // R1 reset while powered down
    wr(2'd1, 8'(LIM));
    wr(2'd0, 8'h01);
    wr(2'd2, 8'hFF);
    strobe();
    repeat (LIM*DIV + 2) @(posedge clk);
    @(negedge clk);
    check("R2 pdn before reset", pdn_o, 1'b1);
    rst_n = 1'b0;
    #2;
    check("R1 reset pdn", pdn_o, 1'b0);
    check("R1 reset turbo", turbo_o, 1'b1);
    pld = 8'h0F;
    #2;
    check("R1 reset mask", pld_o, 8'h0F);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule